// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block resolves a 32-bit virtual address into a 36-bit physical address when the translation cache misses. It is handed a root entry for the current address space and a virtual address. It then reads up to three levels of in-memory tables through a read port that allows one request in flight at a time. Each table level is selected by its own slice of the virtual address. A table descriptor sends the walk one level down. A leaf entry ends the walk at any level, including the root entry itself. An invalid or reserved entry ends the walk with a fault.

A leaf found higher up maps a larger region. The root entry maps the whole 4 GB space, a level-one leaf maps 16 MB, a level-two leaf maps 256 KB and a level-three leaf maps one 4 KB page. The physical address is formed by keeping the upper bits of the leaf's page number and filling the rest with the virtual address. The page offset always passes through untouched. The result is held on a valid/ready response port until the requester takes it. No new request is taken while a walk is in progress.

Top module: `ptw_walker`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, req_ready is 1, rsp_valid is 0 and mem_req_valid is 0.
- R2: req_ready falls in the cycle after a request is accepted and stays low until the cycle after the response is taken. A request offered in the meantime waits, and is accepted in the first cycle req_ready is high again.
- R3: If the root entry is a leaf, no memory read is made. rsp_valid rises in the cycle after acceptance with rsp_level 0 and rsp_paddr = {ppn[23:20], va[31:0]}.
- R4: The read address for level L is {descriptor[31:4], 8'h00} + 4 x index. The index is va[31:24] for L=1, va[23:18] for L=2 and va[17:12] for L=3. The descriptor is the root entry for L=1 and the previous level's entry otherwise.
- R5: Every entry carries its type in bits 1:0, encoded as 0 invalid, 1 table descriptor, 2 leaf and 3 reserved. A leaf holds its page number in bits 31:8 and an attribute/protection field in bits 7:2, which is reported on rsp_attr.
- R6: A leaf read at level 1 ends the walk without further reads. The response has rsp_level 1 and rsp_paddr = {ppn[23:12], va[23:0]}.
- R7: A leaf read at level 2 ends the walk without further reads. The response has rsp_level 2 and rsp_paddr = {ppn[23:6], va[17:0]}.
- R8: A leaf read at level 3 gives rsp_level 3 and rsp_paddr = {ppn[23:0], va[11:0]}.
- R9: A type 0 or 3 entry at any level, or a table descriptor at level 3, ends the walk with rsp_fault 1. rsp_level gives the level of that entry (0 for the root), and rsp_paddr and rsp_attr are 0.
- R10: mem_req_valid stays high with a stable mem_req_addr until mem_req_ready is seen. After a read is accepted, no other read is issued until mem_rsp_valid returns its entry.
- R11: rsp_valid and all response fields stay unchanged until a cycle with rsp_ready high, after which rsp_valid drops.
- R12: Changes on root_entry and req_vaddr after acceptance do not alter the walk or its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| root_entry | input | 32 | Root entry of the current address space, sampled at acceptance |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to accept |
| req_vaddr | input | 32 | Virtual address to translate |
| rsp_valid | output | 1 | Result available |
| rsp_ready | input | 1 | Requester takes the result |
| rsp_paddr | output | 36 | Translated physical address (0 on fault) |
| rsp_attr | output | 6 | Attribute/protection field of the leaf (0 on fault) |
| rsp_level | output | 2 | Level of the leaf, or of the faulting entry |
| rsp_fault | output | 1 | Walk ended on an invalid, reserved or misplaced entry |
| mem_req_valid | output | 1 | Table read request |
| mem_req_ready | input | 1 | Memory takes the read request |
| mem_req_addr | output | 36 | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Entry read from memory |

## Verification
Two events can fall in the same cycle: the requester takes a finished result, and a new request is already waiting on req_valid. The bench raises rsp_ready and req_valid together and then checks three things. The handshake ends the old walk. The new request is not taken in that cycle. It is taken in the next one and starts its own read sequence. The memory port also mixes random stalls on mem_req_ready with random response delays, so that request holds and level changes happen next to each other. Every output is compared against a behavioural model each cycle.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int VA_W      = 32;
  localparam int PA_W      = 36;
  localparam int ENT_W     = 32;
  localparam int OFF_W     = 12;
  localparam int PPN_W     = PA_W - OFF_W;
  localparam int VPN_W     = VA_W - OFF_W;
  localparam int KIND_W    = 2;
  localparam int ATTR_W    = 6;
  localparam int LVL_W     = 2;
  localparam int LAST_LVL  = 3;
  localparam int IX1_W     = 8;
  localparam int IX2_W     = 6;
  localparam int IX3_W     = 6;
  localparam int IX3_LSB   = OFF_W;
  localparam int IX2_LSB   = IX3_LSB + IX3_W;
  localparam int IX1_LSB   = IX2_LSB + IX2_W;
  localparam int IX_MAX_W  = IX1_W;
  localparam int ENT_LOG   = 2;
  localparam int TBL_ALIGN = 8;
  localparam int PTR_LSB   = ENT_W - (PA_W - TBL_ALIGN);
  localparam int ATTR_LSB  = KIND_W;
  localparam int PPN_LSB   = ENT_W - PPN_W;

  typedef enum logic [KIND_W-1:0] {
    KIND_INVALID = 2'd0,
    KIND_TABLE   = 2'd1,
    KIND_LEAF    = 2'd2,
    KIND_RSVD    = 2'd3
  } ent_kind_e;

  function automatic ent_kind_e ent_kind(input logic [ENT_W-1:0] e);
    return ent_kind_e'(e[KIND_W-1:0]);
  endfunction

  function automatic logic [PA_W-1:0] ent_next_base(input logic [ENT_W-1:0] e);
    return {e[ENT_W-1:PTR_LSB], {TBL_ALIGN{1'b0}}};
  endfunction

  // index into the table of level lvl, taken from the page-number part of the address
  function automatic logic [IX_MAX_W-1:0] vpn_index(input logic [VPN_W-1:0] vpn,
                                                    input logic [LVL_W-1:0] lvl);
    case (lvl)
      2'd1:    return vpn[IX1_LSB-OFF_W +: IX1_W];
      2'd2:    return IX_MAX_W'(vpn[IX2_LSB-OFF_W +: IX2_W]);
      2'd3:    return IX_MAX_W'(vpn[IX3_LSB-OFF_W +: IX3_W]);
      default: return '0;
    endcase
  endfunction

  function automatic logic [PA_W-1:0] entry_addr(input logic [PA_W-1:0] base,
                                                 input logic [VPN_W-1:0] vpn,
                                                 input logic [LVL_W-1:0] lvl);
    return base + PA_W'({vpn_index(vpn, lvl), {ENT_LOG{1'b0}}});
  endfunction

  // the larger the region, the more low page-number bits come from the virtual address
  function automatic logic [PA_W-1:0] merge_paddr(input logic [PPN_W-1:0] ppn,
                                                  input logic [VA_W-1:0]  va,
                                                  input logic [LVL_W-1:0] lvl);
    case (lvl)
      2'd0:    return {ppn[PPN_W-1 -: (PA_W-VA_W)], va};
      2'd1:    return {ppn[PPN_W-1 -: (PA_W-IX1_LSB)], va[IX1_LSB-1:0]};
      2'd2:    return {ppn[PPN_W-1 -: (PA_W-IX2_LSB)], va[IX2_LSB-1:0]};
      default: return {ppn, va[OFF_W-1:0]};
    endcase
  endfunction
endpackage

// File: rtl/ptw_ent_decode.sv
module ptw_ent_decode
  import ptw_pkg::*;
(
  input  logic [ENT_W-1:0]  entry,
  output ent_kind_e         kind,
  output logic [PA_W-1:0]   next_base,
  output logic [PPN_W-1:0]  ppn,
  output logic [ATTR_W-1:0] attr
);
  always_comb begin
    kind      = ent_kind(entry);
    next_base = ent_next_base(entry);
    ppn       = entry[PPN_LSB +: PPN_W];
    attr      = entry[ATTR_LSB +: ATTR_W];
  end
endmodule

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen
  import ptw_pkg::*;
(
  input  logic [PA_W-1:0]  base,
  input  logic [VPN_W-1:0] vpn,
  input  logic [LVL_W-1:0] lvl,
  output logic [PA_W-1:0]  addr
);
  always_comb addr = entry_addr(base, vpn, lvl);
endmodule

// File: rtl/ptw_pa_merge.sv
module ptw_pa_merge
  import ptw_pkg::*;
(
  input  logic [PPN_W-1:0] ppn,
  input  logic [VA_W-1:0]  va,
  input  logic [LVL_W-1:0] lvl,
  output logic [PA_W-1:0]  paddr
);
  always_comb paddr = merge_paddr(ppn, va, lvl);
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ENT_W-1:0]  root_entry,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_vaddr,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [PA_W-1:0]   rsp_paddr,
  output logic [ATTR_W-1:0] rsp_attr,
  output logic [LVL_W-1:0]  rsp_level,
  output logic              rsp_fault,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [PA_W-1:0]   mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [ENT_W-1:0]  mem_rsp_data
);
  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_WAIT, S_DONE} walk_state_e;

  walk_state_e       state_q, state_d;
  logic [VA_W-1:0]   va_q;
  logic [LVL_W-1:0]  lvl_q;
  logic [PA_W-1:0]   base_q;
  logic [PA_W-1:0]   res_paddr_q;
  logic [ATTR_W-1:0] res_attr_q;
  logic [LVL_W-1:0]  res_level_q;
  logic              res_fault_q;

  // named internal events
  logic in_idle, ev_accept, ev_mem_issue, ev_mem_return, ev_entry;
  logic ev_descend, ev_leaf, ev_fault, ev_rsp_done;

  logic [ENT_W-1:0]  ent_word;
  logic [LVL_W-1:0]  ent_lvl;
  logic [VA_W-1:0]   ent_va;
  ent_kind_e         dec_kind;
  logic [PA_W-1:0]   dec_base;
  logic [PPN_W-1:0]  dec_ppn;
  logic [ATTR_W-1:0] dec_attr;
  logic [PA_W-1:0]   leaf_paddr;

  assign in_idle       = (state_q == S_IDLE);
  assign ev_accept     = in_idle && req_valid;
  assign ev_mem_issue  = (state_q == S_FETCH) && mem_req_ready;
  assign ev_mem_return = (state_q == S_WAIT) && mem_rsp_valid;
  assign ev_entry      = ev_accept || ev_mem_return;
  assign ev_rsp_done   = (state_q == S_DONE) && rsp_ready;

  // the root entry is evaluated as level 0 at acceptance, memory entries afterwards
  assign ent_word = in_idle ? root_entry : mem_rsp_data;
  assign ent_lvl  = in_idle ? '0 : lvl_q;
  assign ent_va   = in_idle ? req_vaddr : va_q;

  ptw_ent_decode u_decode (
    .entry     (ent_word),
    .kind      (dec_kind),
    .next_base (dec_base),
    .ppn       (dec_ppn),
    .attr      (dec_attr)
  );

  ptw_pa_merge u_merge (
    .ppn   (dec_ppn),
    .va    (ent_va),
    .lvl   (ent_lvl),
    .paddr (leaf_paddr)
  );

  ptw_addr_gen u_addr (
    .base (base_q),
    .vpn  (va_q[VA_W-1:OFF_W]),
    .lvl  (lvl_q),
    .addr (mem_req_addr)
  );

  assign ev_descend = ev_entry && (dec_kind == KIND_TABLE) && (ent_lvl != LVL_W'(LAST_LVL));
  assign ev_leaf    = ev_entry && (dec_kind == KIND_LEAF);
  assign ev_fault   = ev_entry && !ev_descend && !ev_leaf;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE, S_WAIT: begin
        if (ev_descend)              state_d = S_FETCH;
        else if (ev_leaf || ev_fault) state_d = S_DONE;
      end
      S_FETCH: if (mem_req_ready) state_d = S_WAIT;
      S_DONE:  if (rsp_ready)     state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= S_IDLE;
      va_q        <= '0;
      lvl_q       <= '0;
      base_q      <= '0;
      res_paddr_q <= '0;
      res_attr_q  <= '0;
      res_level_q <= '0;
      res_fault_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (ev_accept) va_q <= req_vaddr;
      if (ev_descend) begin
        base_q <= dec_base;
        lvl_q  <= ent_lvl + 1'b1;
      end
      if (ev_leaf) begin
        res_paddr_q <= leaf_paddr;
        res_attr_q  <= dec_attr;
        res_level_q <= ent_lvl;
        res_fault_q <= 1'b0;
      end
      if (ev_fault) begin
        res_paddr_q <= '0;
        res_attr_q  <= '0;
        res_level_q <= ent_lvl;
        res_fault_q <= 1'b1;
      end
    end
  end

  assign req_ready     = in_idle;
  assign mem_req_valid = (state_q == S_FETCH);
  assign rsp_valid     = (state_q == S_DONE);
  assign rsp_paddr     = res_paddr_q;
  assign rsp_attr      = res_attr_q;
  assign rsp_level     = res_level_q;
  assign rsp_fault     = res_fault_q;

  // ---------------- assertions ----------------
  assert_idle_xor_result_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_ready && rsp_valid));

  assert_accept_closes_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept |=> !req_ready);

  assert_read_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  assert_single_outstanding_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_mem_issue |=> !mem_req_valid);

  assert_result_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_paddr) && $stable(rsp_attr)
                                   && $stable(rsp_level) && $stable(rsp_fault)));

  assert_result_taken_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rsp_done |=> !rsp_valid);

  assert_leaf_stops_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_leaf |=> (rsp_valid && !mem_req_valid && !rsp_fault));

  assert_root_leaf_direct_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_accept && ent_kind(root_entry) == KIND_LEAF) |=> (rsp_valid && rsp_level == '0));

  assert_descend_reads_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_descend |=> mem_req_valid);

  assert_fault_zeroed_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> (rsp_paddr == '0 && rsp_attr == '0));

  assert_offset_passes_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_fault) |-> (rsp_paddr[OFF_W-1:0] == va_q[OFF_W-1:0]));
endmodule

// File: tb/sim_ptw_walker.sv
module sim_ptw_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] root_entry = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [35:0] rsp_paddr;
  logic [5:0]  rsp_attr;
  logic [1:0]  rsp_level;
  logic        rsp_fault;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [35:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;

  always #4 clk = ~clk;

  ptw_walker u0 (.*);

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic [31:0] mem [longint];
  longint exp_addrs[$];
  bit     busy = 0;
  bit     await_rsp = 0;
  int     dly = 0;
  longint pend_addr = 0;
  logic [35:0] e_pa;
  logic [5:0]  e_attr;
  int          e_lvl;
  bit          e_fault;
  logic [31:0] lfsr = 32'h1ace_b00c;

  localparam longint B1 = 36'h0_0010_0000;
  localparam longint B2 = 36'h0_0020_0000;
  localparam longint B3 = 36'h0_0030_0100;
  localparam longint B4 = 36'h9_8765_4300;

  function automatic void chk(bit ok, string tag, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endfunction

  function automatic logic [31:0] rnd();
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    return lfsr;
  endfunction

  function automatic logic [31:0] mk_desc(logic [35:0] b);
    return {b[35:8], 2'b00, 2'b01};
  endfunction

  function automatic logic [31:0] mk_leaf(logic [23:0] p, logic [5:0] a);
    return {p, a, 2'b10};
  endfunction

  function automatic void put(longint base, int idx, logic [31:0] e);
    mem[base + idx * 4] = e;
  endfunction

  function automatic logic [31:0] mkva(logic [7:0] i1, logic [5:0] i2, logic [5:0] i3, logic [11:0] off);
    return {i1, i2, i3, off};
  endfunction

  // behavioural walk: fills the expected read sequence and result
  function automatic void ref_walk(logic [31:0] root, logic [31:0] va);
    logic [31:0] ent;
    ent = root;
    exp_addrs.delete();
    for (int lvl = 0; lvl < 4; lvl++) begin
      if (lvl > 0) begin
        longint base, idx, a;
        int sh, wd;
        base = longint'({ent[31:4], 8'h00});
        sh   = (lvl == 1) ? 24 : (lvl == 2) ? 18 : 12;
        wd   = (lvl == 1) ? 8 : 6;
        idx  = (longint'(va) >> sh) & ((64'h1 << wd) - 1);
        a    = base + idx * 4;
        exp_addrs.push_back(a);
        ent  = mem.exists(a) ? mem[a] : 32'h0;
      end
      if (ent[1:0] == 2'd2) begin
        longint span, mask, pa;
        span = (lvl == 0) ? 32 : (lvl == 1) ? 24 : (lvl == 2) ? 18 : 12;
        mask = (64'h1 << span) - 1;
        pa   = (longint'({ent[31:8], 12'h000}) & ~mask) | (longint'(va) & mask);
        e_pa = pa[35:0]; e_attr = ent[7:2]; e_lvl = lvl; e_fault = 0;
        return;
      end
      if (!(ent[1:0] == 2'd1 && lvl < 3)) begin
        e_pa = '0; e_attr = '0; e_lvl = lvl; e_fault = 1;
        return;
      end
    end
  endfunction

  function automatic string lvl_tag();
    if (e_fault) return "R9";
    case (e_lvl)
      0: return "R3";
      1: return "R6";
      2: return "R7";
      default: return "R8";
    endcase
  endfunction

  // cycle monitor and memory model, all at the falling edge
  always @(negedge clk) begin
    if (!rst_n) begin
      busy = 0; await_rsp = 0; exp_addrs.delete();
      mem_req_ready = 0; mem_rsp_valid = 0;
    end else begin
      bit ob, want_mem, want_rsp;
      logic [31:0] t;
      ob = busy;
      want_mem = ob && !await_rsp && exp_addrs.size() > 0;
      want_rsp = ob && !await_rsp && exp_addrs.size() == 0;
      chk(req_ready == !ob, "R2", "req_ready", req_ready, !ob);
      chk(mem_req_valid == want_mem, "R10", "mem_req_valid", mem_req_valid, want_mem);
      if (want_mem && mem_req_valid)
        chk(mem_req_addr == exp_addrs[0][35:0], "R4", "mem_req_addr", mem_req_addr, exp_addrs[0]);
      chk(rsp_valid == want_rsp, "R11", "rsp_valid", rsp_valid, want_rsp);
      if (want_rsp && rsp_valid) begin
        chk(rsp_fault == e_fault, lvl_tag(), "rsp_fault", rsp_fault, e_fault);
        chk(rsp_level == 2'(e_lvl), lvl_tag(), "rsp_level", rsp_level, e_lvl);
        chk(rsp_paddr == e_pa, lvl_tag(), "rsp_paddr", rsp_paddr, e_pa);
        chk(rsp_attr == e_attr, "R5", "rsp_attr", rsp_attr, e_attr);
      end
      // memory data side
      t = rnd();
      if (await_rsp && dly == 0) begin
        mem_rsp_valid = 1;
        mem_rsp_data  = mem.exists(pend_addr) ? mem[pend_addr] : 32'h0;
        await_rsp = 0;
      end else begin
        if (await_rsp) dly--;
        mem_rsp_valid = 0;
        mem_rsp_data  = t;
      end
      // memory request side
      mem_req_ready = (t[9:8] != 2'b00);
      if (mem_req_valid && mem_req_ready && exp_addrs.size() > 0) begin
        pend_addr = exp_addrs.pop_front();
        await_rsp = 1;
        dly = int'(t[12:11]) % 3;
      end
      // requester side
      if (ob && rsp_valid && rsp_ready) busy = 0;
      if (!ob && req_valid) begin
        busy = 1;
        ref_walk(root_entry, req_vaddr);
      end
    end
  end

  task automatic issue(logic [31:0] root, logic [31:0] va, bit scramble);
    @(posedge clk); #1;
    root_entry = root; req_vaddr = va; req_valid = 1;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    @(posedge clk); #1;
    req_valid = 0;
    req_vaddr = rnd();
    if (scramble) root_entry = rnd();
  endtask

  task automatic finish(int d);
    @(negedge clk);
    while (!rsp_valid) @(negedge clk);
    repeat (d) @(negedge clk);
    @(posedge clk); #1 rsp_ready = 1;
    @(posedge clk); #1 rsp_ready = 0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; errors++;
      $display("FAIL R2 watchdog act=%0d exp=150000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] root_d;
    logic [7:0]  l1s [4];
    logic [5:0]  l2s [5];
    logic [5:0]  l3s [6];
    l1s = '{8'h12, 8'h34, 8'h56, 8'h77};
    l2s = '{6'h05, 6'h2A, 6'h3F, 6'h10, 6'h01};
    l3s = '{6'h00, 6'h3F, 6'h11, 6'h20, 6'h15, 6'h02};
    root_d = mk_desc(B1);
    put(B1, 8'h12, mk_desc(B2));
    put(B1, 8'h34, mk_leaf(24'hABCDEF, 6'h05));
    put(B1, 8'h77, 32'h1234_5673);
    put(B2, 6'h05, mk_desc(B3));
    put(B2, 6'h2A, mk_leaf(24'h13579B, 6'h23));
    put(B2, 6'h3F, mk_desc(B4));
    put(B2, 6'h10, 32'h0000_00F3);
    put(B3, 6'h00, mk_leaf(24'hFEDCBA, 6'h3F));
    put(B3, 6'h3F, mk_leaf(24'h000001, 6'h01));
    put(B3, 6'h11, mk_desc(B2));
    put(B4, 6'h15, mk_leaf(24'h5A5A5A, 6'h2A));

    // R1: reset state
    repeat (2) @(negedge clk);
    chk(req_ready == 1, "R1", "req_ready in reset", req_ready, 1);
    chk(rsp_valid == 0, "R1", "rsp_valid in reset", rsp_valid, 0);
    chk(mem_req_valid == 0, "R1", "mem_req_valid in reset", mem_req_valid, 0);
    @(posedge clk); #1 rst_n = 1;
    @(negedge clk);
    chk(req_ready == 1 && rsp_valid == 0 && mem_req_valid == 0, "R1", "after release",
        {req_ready, rsp_valid, mem_req_valid}, 3'b100);

    // R8 full walk, R6 level-1 leaf, R7 level-2 leaf, R3 root leaf
    issue(root_d, mkva(8'h12, 6'h05, 6'h00, 12'h5A5), 0); finish(0);
    issue(root_d, mkva(8'h34, 6'h3A, 6'h2B, 12'h123), 0); finish(2);
    issue(root_d, mkva(8'h12, 6'h2A, 6'h19, 12'hFFF), 0); finish(1);
    issue(root_d, mkva(8'h12, 6'h3F, 6'h15, 12'h001), 0); finish(0);
    issue(mk_leaf(24'hC12345, 6'h11), 32'hDEAD_BEEF, 0); finish(3);
    // R9 faults at each level
    issue(32'h0000_0000, 32'h1234_5678, 0); finish(0);
    issue(32'hFFFF_FFF3, 32'h1234_5678, 0); finish(0);
    issue(root_d, mkva(8'h56, 6'h00, 6'h00, 12'h000), 0); finish(0);
    issue(root_d, mkva(8'h77, 6'h00, 6'h00, 12'h000), 0); finish(0);
    issue(root_d, mkva(8'h12, 6'h10, 6'h00, 12'h000), 0); finish(0);
    issue(root_d, mkva(8'h12, 6'h05, 6'h11, 12'h000), 0); finish(0);
    issue(root_d, mkva(8'h12, 6'h05, 6'h20, 12'h000), 0); finish(1);

    // R12: inputs scrambled right after acceptance
    issue(root_d, mkva(8'h12, 6'h05, 6'h00, 12'h777), 1);
    @(negedge clk);
    while (!rsp_valid) @(negedge clk);
    chk(rsp_paddr == {24'hFEDCBA, 12'h777} && !rsp_fault, "R12", "walk after input change",
        rsp_paddr, {24'hFEDCBA, 12'h777});
    @(posedge clk); #1 rsp_ready = 1;
    @(posedge clk); #1 rsp_ready = 0;

    // R2: result taken in the same cycle a new request is already offered
    issue(root_d, mkva(8'h34, 6'h01, 6'h01, 12'h010), 0);
    @(negedge clk);
    while (!rsp_valid) @(negedge clk);
    @(posedge clk); #1;
    rsp_ready = 1; req_valid = 1; root_entry = root_d; req_vaddr = mkva(8'h12, 6'h05, 6'h3F, 12'hABC);
    @(negedge clk);
    chk(req_ready == 0 && rsp_valid == 1, "R2", "not taken while result pending",
        {req_ready, rsp_valid}, 2'b01);
    @(posedge clk); #1 rsp_ready = 0;
    @(negedge clk);
    chk(req_ready == 1 && rsp_valid == 0, "R2", "idle after result taken",
        {req_ready, rsp_valid}, 2'b10);
    @(posedge clk); #1 req_valid = 0;
    @(negedge clk);
    chk(req_ready == 0, "R2", "waiting request accepted", req_ready, 0);
    finish(0);

    // mixed addresses over the same tables
    for (int n = 0; n < 40; n++) begin
      logic [31:0] r;
      r = rnd();
      issue(root_d, mkva(l1s[r[1:0]], l2s[int'(r[6:4]) % 5], l3s[int'(r[10:8]) % 6], r[27:16]), r[28]);
      finish(int'(r[30:29]));
    end

    repeat (4) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule